// File: doc/BRIEF.md
# Dual-Clock FIFO with Offset Flags

This block is a 64-entry, 36-bit first-in first-out buffer. Its producer and consumer sit on two unrelated clocks. Each side exchanges words through a valid/ready handshake. Write and read pointers are held as gray-coded counters, and each pointer reaches the opposite domain through a two-stage synchronizer. Each domain therefore sees a fill level that lags the other side's activity by two of its own clock edges.

The read side drives an active-low almost-empty flag and the write side drives an active-low almost-full flag. Both flags compare the fill level against one shared offset X. X is picked from four presets by a 2-bit select that is sampled while reset is held low.

Back-pressure rules are as follows. A word is taken on a rising `wr_clk` edge only when `wr_valid` and `wr_ready` are both high. `wr_ready` falls when the write side counts 64 stored words. A word leaves on a rising `rd_clk` edge only when `rd_valid` and `rd_ready` are both high. `rd_data` shows the oldest stored word whenever `rd_valid` is high. The producer may hold `wr_valid` high while `wr_ready` is low, and the consumer may hold `rd_ready` high while `rd_valid` is low. Neither has any effect.

Top module: `dual_clock_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with all 36 bits intact, and up to 64 words are held.
- R2: `wr_ready` is low while the write side counts 64 stored words. A write offered while `wr_ready` is low is dropped and never appears at the output.
- R3: `rd_valid` is high while the read side counts at least one word, and `rd_data` then shows the oldest word. A read requested while `rd_valid` is low changes nothing.
- R4: `almost_empty_n` is low when the read-side count is X or less, and high when it is X+1 or more. A local read takes effect on the edge that performs it.
- R5: `almost_full_n` is low when the write-side count is 64−X or more, and high when it is 63−X or less. A local write takes effect on the edge that performs it.
- R6: A write becomes visible to `rd_valid` and `almost_empty_n` on the second rising `rd_clk` edge after it, and not on the first.
- R7: A read becomes visible to `wr_ready` and `almost_full_n` on the second rising `wr_clk` edge after it, and not on the first.
- R8: X equals 4 shifted left by `ofs_sel`, so that select 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32. X is captured on clock edges while `rst_n` is low, and later changes of `ofs_sel` are ignored until the next reset.
- R9: After `rst_n` has been held low for at least two edges of each clock, the block is empty: `rd_valid` is low, `wr_ready` is high, `almost_empty_n` is low and `almost_full_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ofs_sel | input | 2 | Offset preset select, captured during reset |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | Space available; handshake completes when both high |
| wr_data | input | 36 | Word to store |
| almost_full_n | output | 1 | Low when 64−X or more words stored (write domain) |
| rd_ready | input | 1 | Consumer takes the presented word |
| rd_valid | output | 1 | A word is presented on `rd_data` |
| rd_data | output | 36 | Oldest stored word |
| almost_empty_n | output | 1 | Low when X or fewer words stored (read domain) |

## Verification
The bench builds the block with its default parameters: 36-bit words, a depth of 64 and an offset base of 4. With these values every preset from 4 to 32 can be selected, and the full and almost-full boundaries are only a few dozen writes away. The bench sweeps the fill level one word at a time for each preset, so both flag thresholds are seen on both sides. The two clocks are chosen so that their edges never coincide. This lets the bench count the exact crossing edge for the two-edge latency in each direction.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int AW       = 6,
  parameter int OFS_BASE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ofs_sel,
  input  logic        valid,
  output logic        ready,
  output logic        push,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray,
  input  logic [AW:0] rgray_s,
  output logic        almost_full_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin, rbin_s, used, ofs;

  assign rbin_s = PW'(dcf_pkg::gray_to_bin(32'(rgray_s)));
  assign used   = wbin - rbin_s;
  assign ready  = (used != PW'(DEPTH));
  assign push   = valid && ready;
  assign waddr  = wbin[AW-1:0];
  assign almost_full_n = (used < (PW'(DEPTH) - ofs));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin + 1'b1;
      wgray <= PW'(dcf_pkg::bin_to_gray(32'(wbin + 1'b1)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ofs <= PW'(OFS_BASE) << ofs_sel;
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));
  // R2
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> $stable(wgray));
  // R5
  full_implies_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !almost_full_n);
  // R6
  wr_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
  // R8
  wr_offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ofs));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int AW       = 6,
  parameter int OFS_BASE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ofs_sel,
  input  logic        ready,
  output logic        valid,
  output logic [AW-1:0] raddr,
  output logic [AW:0] rgray,
  input  logic [AW:0] wgray_s,
  output logic        almost_empty_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin, wbin_s, level, ofs;
  logic          pop;

  assign wbin_s = PW'(dcf_pkg::gray_to_bin(32'(wgray_s)));
  assign level  = wbin_s - rbin;
  assign valid  = (level != '0);
  assign pop    = valid && ready;
  assign raddr  = rbin[AW-1:0];
  assign almost_empty_n = (level > ofs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin + 1'b1;
      rgray <= PW'(dcf_pkg::bin_to_gray(32'(rbin + 1'b1)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ofs <= PW'(OFS_BASE) << ofs_sel;
  end

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PW'(DEPTH));
  // R3
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && ready) |=> $stable(rgray));
  // R4
  empty_implies_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !almost_empty_n);
  // R7
  rd_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));
  // R8
  rd_offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ofs));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DW       = 36,
  parameter int AW       = 6,
  parameter int OFS_BASE = 4
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [1:0]    ofs_sel,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          almost_full_n,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          almost_empty_n
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          push;

  dcf_wr_side #(.AW(AW), .OFS_BASE(OFS_BASE)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
    .valid(wr_valid), .ready(wr_ready), .push(push),
    .waddr(waddr), .wgray(wgray), .rgray_s(rgray_s),
    .almost_full_n(almost_full_n)
  );

  dcf_rd_side #(.AW(AW), .OFS_BASE(OFS_BASE)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
    .ready(rd_ready), .valid(rd_valid),
    .raddr(raddr), .rgray(rgray), .wgray_s(wgray_s),
    .almost_empty_n(almost_empty_n)
  );

  dcf_sync2 #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  dcf_sync2 #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/dual_clock_fifo_test.sv
`timescale 1ns/100ps
module dual_clock_fifo_test;
  logic        wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic [1:0]  ofs_sel = 0;
  logic        wr_valid = 0, rd_ready = 0;
  logic [35:0] wr_data = '0;
  logic        wr_ready, almost_full_n, rd_valid, almost_empty_n;
  logic [35:0] rd_data;

  int checks = 0, errors = 0;
  logic [35:0] q[$];

  dual_clock_fifo uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .almost_full_n(almost_full_n), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .almost_empty_n(almost_empty_n)
  );

  // 50 MHz write clock; read clock edges fall on odd ns, never coinciding
  always #10 wr_clk = ~wr_clk;
  initial begin #3; forever #14 rd_clk = ~rd_clk; end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst_n = 0; ofs_sel = s; wr_valid = 0; rd_ready = 0; q.delete();
    repeat (4) @(posedge rd_clk);
    @(posedge wr_clk); #0.5; rst_n = 1; #1;
  endtask

  task automatic push(input logic [35:0] d);
    wr_valid = 1; wr_data = d;
    if (wr_ready) q.push_back(d);
    @(posedge wr_clk); #0.5;
    wr_valid = 0;
  endtask

  task automatic pop_chk(input string req);
    logic [35:0] e;
    int n = 0;
    while (!rd_valid && n < 10) begin @(posedge rd_clk); #0.5; n++; end
    e = q.pop_front();
    chk(rd_valid === 1'b1, req, "rd_valid", 64'(rd_valid), 64'd1);
    chk(rd_data === e, req, "rd_data", 64'(rd_data), 64'(e));
    rd_ready = 1;
    @(posedge rd_clk); #0.5;
    rd_ready = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge rd_clk);
    #0.5;
  endtask

  task automatic t_reset();
    do_reset(2'd0);
    chk(rd_valid === 0, "R9", "rd_valid", 64'(rd_valid), 0);
    chk(wr_ready === 1, "R9", "wr_ready", 64'(wr_ready), 1);
    chk(almost_empty_n === 0, "R9", "almost_empty_n", 64'(almost_empty_n), 0);
    chk(almost_full_n === 1, "R9", "almost_full_n", 64'(almost_full_n), 1);
  endtask

  task automatic t_order();
    do_reset(2'd0);
    for (int i = 0; i < 20; i++) push({4'hA, 32'(i * 32'h01010101 + 7)});
    settle();
    chk(almost_empty_n === 1, "R4", "ae_n at 20", 64'(almost_empty_n), 1);
    for (int i = 0; i < 15; i++) pop_chk("R1");
    chk(almost_empty_n === 1, "R4", "ae_n at X+1", 64'(almost_empty_n), 1);
    pop_chk("R1");
    chk(almost_empty_n === 0, "R4", "ae_n at X", 64'(almost_empty_n), 0);
    for (int i = 0; i < 4; i++) pop_chk("R3");
    chk(rd_valid === 0, "R3", "rd_valid drained", 64'(rd_valid), 0);
    rd_ready = 1; repeat (2) @(posedge rd_clk); #0.5; rd_ready = 0;
    push(36'h5_5AA5_0F0F);
    settle();
    pop_chk("R3");
    chk(rd_valid === 0, "R3", "empty after read-while-empty", 64'(rd_valid), 0);
  endtask

  task automatic t_ae_latency();
    do_reset(2'd0);
    push(36'h1_0000_0001);
    @(posedge rd_clk); #0.5;
    chk(rd_valid === 0, "R6", "rd_valid 1st edge", 64'(rd_valid), 0);
    @(posedge rd_clk); #0.5;
    chk(rd_valid === 1, "R6", "rd_valid 2nd edge", 64'(rd_valid), 1);
    for (int i = 0; i < 3; i++) push(36'(i + 2));
    settle();
    chk(almost_empty_n === 0, "R6", "ae_n at X", 64'(almost_empty_n), 0);
    push(36'h5);
    @(posedge rd_clk); #0.5;
    chk(almost_empty_n === 0, "R6", "ae_n 1st edge", 64'(almost_empty_n), 0);
    @(posedge rd_clk); #0.5;
    chk(almost_empty_n === 1, "R6", "ae_n 2nd edge", 64'(almost_empty_n), 1);
  endtask

  task automatic t_full();
    do_reset(2'd0);
    for (int i = 0; i < 59; i++) push(36'(i) ^ 36'hC_3C3C_0000);
    chk(almost_full_n === 1, "R5", "af_n at 63-X", 64'(almost_full_n), 1);
    push(36'hC_0000_0059);
    chk(almost_full_n === 0, "R5", "af_n at 64-X", 64'(almost_full_n), 0);
    for (int i = 0; i < 4; i++) push(36'hD_0000_0000 + 36'(i));
    chk(wr_ready === 0, "R2", "wr_ready at 64", 64'(wr_ready), 0);
    chk(q.size() == 64, "R1", "accepted count", 64'(q.size()), 64);
    push(36'hF_DEAD_BEEF);
    chk(q.size() == 64, "R2", "write while full", 64'(q.size()), 64);
    settle();
    pop_chk("R1");
    @(posedge wr_clk); #0.5;
    chk(wr_ready === 0, "R7", "wr_ready 1st edge", 64'(wr_ready), 0);
    @(posedge wr_clk); #0.5;
    chk(wr_ready === 1, "R7", "wr_ready 2nd edge", 64'(wr_ready), 1);
    for (int i = 0; i < 4; i++) pop_chk("R1");
    @(posedge wr_clk); #0.5;
    chk(almost_full_n === 0, "R7", "af_n 1st edge", 64'(almost_full_n), 0);
    @(posedge wr_clk); #0.5;
    chk(almost_full_n === 1, "R7", "af_n 2nd edge", 64'(almost_full_n), 1);
    while (q.size() > 0) pop_chk("R2");
    settle();
    chk(rd_valid === 0, "R2", "dropped word absent", 64'(rd_valid), 0);
  endtask

  task automatic t_offsets();
    for (int s = 0; s < 4; s++) begin
      int x = 4 << s;
      do_reset(2'(s));
      ofs_sel = 2'(~s);
      for (int c = 1; c <= 64 - x; c++) begin
        push(36'(c));
        settle();
        chk(almost_empty_n === (c > x), "R8", $sformatf("ae_n sel%0d c%0d", s, c),
            64'(almost_empty_n), 64'(c > x));
        chk(almost_full_n === (c < 64 - x), "R8", $sformatf("af_n sel%0d c%0d", s, c),
            64'(almost_full_n), 64'(c < 64 - x));
      end
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_ae_latency();
    t_full();
    t_offsets();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule